// File: doc/BRIEF.md
# Operation Mode and Event Gating Controller

This block owns the 8-bit operation control register of a device that talks to a host controller over a request/reply link. It decides whether outbound messages may leave the device. Unsolicited event messages are allowed only in the Active mode while the link to the host is up. Replies can be muted. A once-per-second beacon produces either a status event or a legacy seconds-count event. A write that sets the dump bit starts a sequencer. The sequencer walks a fixed list of register addresses and hands one read request per address to a downstream message builder.

The host write path presents a one-cycle write strobe with the new register value. The block answers with the current read-back value and a one-cycle error pulse. A level input reports whether the host link is connected. This input may be asynchronous and passes through a two-flop synchronizer. Losing the link drops the device into Standby without any host action. The dump list has two parts: the core addresses 0 to CORE_CNT-1, then APP_CNT application addresses starting at APP_BASE. Each address is held until the downstream consumer accepts it.

Top module: `opmode_event_gate`

## Requirements
- R1: After reset the read-back value `ctrl_rd` is 0xE4. That is: bit 7 alive enable = 1, bits 6 and 5 = 1, bit 4 mute = 0, bit 3 dump = 0, bit 2 heartbeat enable = 1, and bits [1:0] mode = 0. `mode` is 0 (Standby), and `event_en`, `reply_mute`, `hb_evt_req` and `alive_evt_req` are 0.
- R2: A write (`wr_en` high for one cycle) with mode field `wr_data[1:0]` equal to 0 (Standby) or 1 (Active) takes effect in the cycle after the write. `event_en` is 1 exactly when the mode is Active and the synchronized link is up.
- R3: A write with mode field 2 or 3 leaves `mode` unchanged. It still updates bits 7..4 and 2. It pulses `wr_err` for one cycle after the write, unless bit 4 of the written value is 1.
- R4: After `link_up` falls, `mode` reads Standby and `event_en` reads 0 by the third rising clock edge. While the link is down, writes cannot select Active. Such writes raise no error.
- R5: With bit 2 set and the mode Active, a one-cycle `sec_tick` produces a one-cycle `hb_evt_req` pulse in the cycle after the tick.
- R6: With bit 7 set and bit 2 clear, a tick in Active mode gives an `alive_evt_req` pulse instead. With both bits set, only `hb_evt_req` pulses.
- R7: No heartbeat or alive request is produced while the mode is Standby or the link is down.
- R8: `reply_mute` follows bit 4 of the register.
- R9: Writing 1 to bit 3, with bit 4 of the written value 0, pulses `dump_start` in the cycle after the write. Bit 3 always reads back 0. A dump write whose value has bit 4 set starts nothing.
- R10: `dump_valid` rises in the cycle after `dump_start`. `dump_addr` then presents 0..CORE_CNT-1, followed by APP_BASE..APP_BASE+APP_CNT-1 (defaults 20, 32, 8). The address advances only on a cycle with `dump_valid` and `dump_ready` both high. `dump_done` pulses in the cycle after the final handshake, and `dump_valid` is then 0.
- R11: `status_word` bit 0 is 1 only in Active mode. Bit 1 is `ext_synced` OR `clk_gen_role`. Bits 15:2 are 0.
- R12: A dump write arriving while a dump is running does not pulse `dump_start` and does not disturb the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Value written with `wr_en` |
| link_up | input | 1 | Host link connected level, asynchronous |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ext_synced | input | 1 | Locked to an external clock source |
| clk_gen_role | input | 1 | Device is itself the clock generator |
| dump_ready | input | 1 | Downstream accepts the presented dump address |
| ctrl_rd | output | 8 | Read-back value of the control register, bit 3 always 0 |
| mode | output | 2 | Current operation mode, 0 Standby, 1 Active |
| event_en | output | 1 | Event messages may be sent |
| reply_mute | output | 1 | Replies, including error replies, are suppressed |
| wr_err | output | 1 | One-cycle error indication for an unsupported mode write |
| hb_evt_req | output | 1 | Request for a status event |
| alive_evt_req | output | 1 | Request for a seconds-count event |
| status_word | output | 16 | Device status word |
| dump_start | output | 1 | One-cycle pulse that starts a dump |
| dump_valid | output | 1 | A dump address is presented |
| dump_addr | output | AW (8) | Register address to be read for the dump |
| dump_done | output | 1 | One-cycle pulse after the last address is accepted |

## Verification
The bench targets rejected mode writes. A design that stored the reserved or legacy mode value would show mode 2 or 3. A design that ignored the mute bit on the error path would pulse `wr_err` even though the write muted it. It also drops the link during Active mode and then writes Active. A design without the forcing path would keep issuing heartbeats or return to Active on its own. Both priority cases of the one-second beacon are covered, so a design with the wrong priority would raise both requests, or the legacy one. The dump walk is run with a stalled consumer, with a second dump write mid-walk, and across the jump from core to application addresses. This exposes an address that advances without a handshake, a restart, a skipped or duplicated address, and a start pulse raised in the same cycle as the write.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_ACTIVE  = 2'd1,
    MODE_RSVD    = 2'd2,
    MODE_SPEED   = 2'd3
  } opm_mode_e;

  localparam int BIT_HB    = 2;
  localparam int BIT_DUMP  = 3;
  localparam int BIT_MUTE  = 4;
  localparam int BIT_ALIVE = 7;

  localparam logic [7:0] CTRL_RST = 8'hE4;

  function automatic logic mode_supported(input logic [1:0] m);
    return (m == MODE_STANDBY) || (m == MODE_ACTIVE);
  endfunction

  function automatic logic [15:0] status_pack(input logic active, input logic synced);
    return {14'd0, synced, active};
  endfunction

endpackage

// File: rtl/opm_link_sync.sv
module opm_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/opm_ctrl_reg.sv
module opm_ctrl_reg
  import opm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       link_ok,
  input  logic       dump_busy,
  output logic [7:0] ctrl_q,
  output logic       wr_err,
  output logic       dump_start
);
  logic mode_ok;
  logic dump_req;

  assign mode_ok  = mode_supported(wr_data[1:0]);
  assign dump_req = wr_en && wr_data[BIT_DUMP] && !wr_data[BIT_MUTE] && !dump_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      wr_err     <= 1'b0;
      dump_start <= 1'b0;
    end else begin
      wr_err     <= 1'b0;
      dump_start <= dump_req;
      if (wr_en) begin
        ctrl_q[7:4]      <= wr_data[7:4];
        ctrl_q[BIT_HB]   <= wr_data[BIT_HB];
        ctrl_q[BIT_DUMP] <= 1'b0;
        if (mode_ok) ctrl_q[1:0] <= link_ok ? wr_data[1:0] : MODE_STANDBY;
        else         wr_err      <= !wr_data[BIT_MUTE];
      end
      if (!link_ok) ctrl_q[1:0] <= MODE_STANDBY;
    end
  end
endmodule

// File: rtl/opm_beacon.sv
module opm_beacon (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic event_en,
  input  logic hb_en,
  input  logic alive_en,
  output logic hb_req,
  output logic alive_req
);
  logic tick_fire;

  assign tick_fire = sec_tick && event_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_req    <= 1'b0;
      alive_req <= 1'b0;
    end else begin
      hb_req    <= tick_fire && hb_en;
      alive_req <= tick_fire && alive_en && !hb_en;
    end
  end
endmodule

// File: rtl/opm_dump_seq.sv
module opm_dump_seq #(
  parameter int CORE_CNT = 20,
  parameter int APP_BASE = 32,
  parameter int APP_CNT  = 8,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int TOTAL = CORE_CNT + APP_CNT;
  localparam int IW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  function automatic logic [AW-1:0] addr_of(input logic [IW-1:0] i);
    int k;
    k = int'(i);
    if (k < CORE_CNT) return AW'(k);
    return AW'(APP_BASE + k - CORE_CNT);
  endfunction

  logic [IW-1:0] idx_q;
  logic          hs;
  logic          last_hs;

  assign hs      = busy && ready;
  assign last_hs = hs && (idx_q == IW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_hs;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx_q <= '0;
        end
      end else if (last_hs) begin
        busy  <= 1'b0;
        idx_q <= '0;
      end else if (hs) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign addr = addr_of(idx_q);
endmodule

// File: rtl/opmode_event_gate.sv
module opmode_event_gate
  import opm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CORE_CNT    = 20,
  parameter int APP_BASE    = 32,
  parameter int APP_CNT     = 8,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          link_up,
  input  logic          sec_tick,
  input  logic          ext_synced,
  input  logic          clk_gen_role,
  input  logic          dump_ready,
  output logic [7:0]    ctrl_rd,
  output logic [1:0]    mode,
  output logic          event_en,
  output logic          reply_mute,
  output logic          wr_err,
  output logic          hb_evt_req,
  output logic          alive_evt_req,
  output logic [15:0]   status_word,
  output logic          dump_start,
  output logic          dump_valid,
  output logic [AW-1:0] dump_addr,
  output logic          dump_done
);
  logic       link_ok;
  logic [7:0] ctrl_q;
  logic       is_active;

  opm_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(link_up), .sync_out(link_ok)
  );

  opm_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .link_ok(link_ok), .dump_busy(dump_valid), .ctrl_q(ctrl_q),
    .wr_err(wr_err), .dump_start(dump_start)
  );

  assign mode       = ctrl_q[1:0];
  assign is_active  = (mode == MODE_ACTIVE);
  assign event_en   = is_active && link_ok;
  assign reply_mute = ctrl_q[BIT_MUTE];
  assign ctrl_rd    = ctrl_q;
  assign status_word = status_pack(is_active, ext_synced || clk_gen_role);

  opm_beacon u_beacon (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .event_en(event_en),
    .hb_en(ctrl_q[BIT_HB]), .alive_en(ctrl_q[BIT_ALIVE]),
    .hb_req(hb_evt_req), .alive_req(alive_evt_req)
  );

  opm_dump_seq #(
    .CORE_CNT(CORE_CNT), .APP_BASE(APP_BASE), .APP_CNT(APP_CNT), .AW(AW)
  ) u_dump (
    .clk(clk), .rst_n(rst_n), .start(dump_start), .ready(dump_ready),
    .busy(dump_valid), .addr(dump_addr), .done(dump_done)
  );
endmodule

// File: rtl/opmode_event_gate_chk.sv
module opmode_event_gate_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          event_en,
  input logic          link_ok,
  input logic          hb_evt_req,
  input logic          alive_evt_req,
  input logic          dump_start,
  input logic          dump_valid,
  input logic          dump_ready,
  input logic [AW-1:0] dump_addr,
  input logic          dump_done
);
  AST_BEACON_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_evt_req && alive_evt_req)); // R6
  AST_BEACON_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_evt_req || alive_evt_req) |-> $past(event_en)); // R7
  AST_LINK_DOWN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> (mode == 2'd0)); // R4
  AST_MODE_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) || (mode == 2'd1)); // R3
  AST_DUMP_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_valid) |-> $past(dump_start)); // R10
  AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && !dump_ready) |=> (dump_valid && $stable(dump_addr))); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dump_done |-> !dump_valid); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dump_start |-> !dump_valid); // R12
endmodule

bind opmode_event_gate opmode_event_gate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .event_en(event_en), .link_ok(link_ok),
  .hb_evt_req(hb_evt_req), .alive_evt_req(alive_evt_req),
  .dump_start(dump_start), .dump_valid(dump_valid), .dump_ready(dump_ready),
  .dump_addr(dump_addr), .dump_done(dump_done)
);

// File: tb/test_opmode_event_gate.sv
module test_opmode_event_gate;
  localparam int CORE_N = 20;
  localparam int APP_B  = 32;
  localparam int APP_N  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic link_up = 1'b1;
  logic sec_tick = 1'b0;
  logic ext_synced = 1'b0;
  logic clk_gen_role = 1'b0;
  logic dump_ready = 1'b0;
  logic [7:0] ctrl_rd;
  logic [1:0] mode;
  logic event_en, reply_mute, wr_err, hb_evt_req, alive_evt_req;
  logic [15:0] status_word;
  logic dump_start, dump_valid, dump_done;
  logic [7:0] dump_addr;

  int n_total = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  opmode_event_gate i_opmode_event_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .link_up(link_up),
    .sec_tick(sec_tick), .ext_synced(ext_synced), .clk_gen_role(clk_gen_role),
    .dump_ready(dump_ready), .ctrl_rd(ctrl_rd), .mode(mode), .event_en(event_en),
    .reply_mute(reply_mute), .wr_err(wr_err), .hb_evt_req(hb_evt_req),
    .alive_evt_req(alive_evt_req), .status_word(status_word), .dump_start(dump_start),
    .dump_valid(dump_valid), .dump_addr(dump_addr), .dump_done(dump_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  function automatic int exp_addr(input int i);
    if (i >= CORE_N) return APP_B + (i - CORE_N);
    return i;
  endfunction

  task automatic t_reset();
    chk("R1 ctrl_rd", ctrl_rd, 8'hE4);
    chk("R1 mode", mode, 0);
    chk("R1 event_en", event_en, 0);
    chk("R1 reply_mute", reply_mute, 0);
    chk("R1 beacons", {hb_evt_req, alive_evt_req}, 0);
    chk("R11 status standby", status_word, 0);
  endtask

  task automatic t_standby_quiet();
    tick();
    chk("R7 standby beacons", {hb_evt_req, alive_evt_req}, 0);
  endtask

  task automatic t_active_and_beacons();
    wr(8'hE5);
    chk("R2 mode active", mode, 1);
    chk("R2 event_en", event_en, 1);
    chk("R11 status active", status_word, 1);
    tick();
    chk("R5 R6 heartbeat wins", {hb_evt_req, alive_evt_req}, 2'b10);
    @(negedge clk);
    chk("R5 one-cycle pulse", hb_evt_req, 0);
    wr(8'hE1);
    tick();
    chk("R6 alive only", {hb_evt_req, alive_evt_req}, 2'b01);
    wr(8'h61);
    tick();
    chk("R6 neither enabled", {hb_evt_req, alive_evt_req}, 0);
    wr(8'hE5);
  endtask

  task automatic t_bad_mode();
    wr(8'hE6);
    chk("R3 err pulse", wr_err, 1);
    chk("R3 mode kept", mode, 1);
    chk("R3 readback", ctrl_rd, 8'hE5);
    @(negedge clk);
    chk("R3 err one cycle", wr_err, 0);
    wr(8'hF7);
    chk("R3 muted err", wr_err, 0);
    chk("R8 mute set", reply_mute, 1);
    chk("R3 readback muted", ctrl_rd, 8'hF5);
    wr(8'hE5);
    chk("R8 mute clear", reply_mute, 0);
  endtask

  task automatic t_status();
    ext_synced = 1'b1;
    @(negedge clk);
    chk("R11 synced", status_word, 3);
    ext_synced = 1'b0; clk_gen_role = 1'b1;
    @(negedge clk);
    chk("R11 generator", status_word, 3);
    wr(8'hE4);
    chk("R11 standby gen", status_word, 2);
    clk_gen_role = 1'b0;
    wr(8'hE5);
  endtask

  task automatic t_link_loss();
    @(negedge clk); link_up = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 forced standby", mode, 0);
    chk("R4 events off", event_en, 0);
    tick();
    chk("R7 link down beacons", {hb_evt_req, alive_evt_req}, 0);
    wr(8'hE5);
    chk("R4 active blocked", mode, 0);
    chk("R4 no error", wr_err, 0);
    link_up = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 stays standby", mode, 0);
    wr(8'hE5);
    chk("R2 active again", mode, 1);
  endtask

  task automatic t_dump();
    wr(8'hED);
    chk("R9 start pulse", dump_start, 1);
    chk("R9 bit3 reads 0", ctrl_rd, 8'hE5);
    chk("R10 not yet valid", dump_valid, 0);
    @(negedge clk);
    chk("R10 valid after start", {dump_valid, dump_start}, 2'b10);
    chk("R10 first addr", dump_addr, 0);
    @(negedge clk);
    chk("R10 stall holds", {dump_valid, dump_addr}, 9'h100);
    wr(8'hED);
    chk("R12 no restart", dump_start, 0);
    chk("R12 walk intact", {dump_valid, dump_addr}, 9'h100);
    dump_ready = 1'b1;
    for (int i = 0; i < CORE_N + APP_N; i++) begin
      chk("R10 walk addr", {dump_valid, dump_addr}, 9'h100 | exp_addr(i));
      @(negedge clk);
    end
    chk("R10 done", {dump_done, dump_valid}, 2'b10);
    dump_ready = 1'b0;
    @(negedge clk);
    chk("R10 done one cycle", dump_done, 0);
    wr(8'hFD);
    chk("R9 muted dump no start", dump_start, 0);
    @(negedge clk);
    chk("R9 muted dump idle", dump_valid, 0);
    wr(8'hE5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_standby_quiet();
    t_active_and_beacons();
    t_bad_mode();
    t_status();
    t_link_loss();
    t_dump();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule